// File: doc/BRIEF.md
# Line-Invalidate Store Backup Queue

This block keeps an ordered list of pending store records, each an address and a data word. It serves a cache model in which a line may be allocated and written without a fill, and then invalidated later. One command port carries three kinds of request. A capture adds a record when the store targets a cacheable region. A discard clears the whole list. An invalidate names an address and replays every queued record in that address's 32-byte line as a memory write, oldest first, removing each record as its write is taken.

Commands use a valid/ready handshake. `cmd_ready` is low while an invalidate scan runs, so the sender must hold a command until it is accepted. Memory writes leave on a second valid/ready port. Once `wr_valid` rises, the address and data hold still until `wr_ready` is seen high at a clock edge, and the scan does not move on while the port is stalled. The queue depth, the fill count and the overflow indication come out as plain status pins.

Top module: `lbq_top`

## Requirements
- R1: After reset, `count` is 0, `empty` is 1, `full`, `busy`, `wr_valid` and `overflow` are 0, and `cmd_ready` is 1.
- R2: An accepted capture (`cmd_op` = 2'b00) with `cmd_cacheable` = 1 appends `{cmd_addr, cmd_data}` at the tail, and `count` rises by one on the next cycle. With `cmd_cacheable` = 0 the queue is left unchanged.
- R3: A cacheable capture accepted while `count` equals DEPTH (8) drops the record. `count` stays at 8 and `overflow` is high for exactly the one following cycle. `full` is 1 whenever `count` is 8.
- R4: An accepted discard (`cmd_op` = 2'b01) sets `count` to 0 on the next cycle and produces no memory write.
- R5: An accepted invalidate (`cmd_op` = 2'b10) produces one write for each queued record whose address bits [31:5] equal those of `cmd_addr`. Each write carries the stored address and data, the writes come in capture order, and each record leaves the queue when its write is accepted.
- R6: Records outside the invalidated line stay queued in their original relative order.
- R7: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` keep their values on the next cycle.
- R8: `busy` is 1 from the cycle after an invalidate is accepted until every matching write has been accepted, and for at least one cycle even when nothing matches. While `busy` is 1, `cmd_ready` is 0 and no command takes effect. `wr_valid` is 0 whenever `busy` is 0.
- R9: An accepted command with `cmd_op` = 2'b11 has no effect on the queue, and no scan starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when valid is high |
| cmd_op | input | 2 | 00 capture, 01 discard, 10 invalidate, 11 no operation |
| cmd_addr | input | 32 | Store address (capture) or line address (invalidate) |
| cmd_data | input | 32 | Store data for a capture |
| cmd_cacheable | input | 1 | The capture address lies in a cacheable region |
| wr_valid | output | 1 | Memory write offered |
| wr_ready | input | 1 | Memory takes the write |
| wr_addr | output | 32 | Write address |
| wr_data | output | 32 | Write data |
| busy | output | 1 | Invalidate scan in progress |
| count | output | 4 | Number of queued records |
| full | output | 1 | Queue holds DEPTH records |
| empty | output | 1 | Queue holds no record |
| overflow | output | 1 | One-cycle pulse after a dropped capture |

## Verification
A record shifted into the wrong slot during compaction shows up at the write port as a later invalidate emitting writes out of capture order, or with an address paired with the wrong data word. A count that drifts from the real contents shows on `count` on the cycle after the faulty update, and then as missing or extra writes when the line is invalidated. A scan pointer that skips or repeats an entry shows within the same scan as a missing or duplicated write, or as `busy` staying high. A scan that ignores back-pressure shows on the first stalled cycle as `wr_addr` or `wr_data` changing before the write is taken.

// File: rtl/lbq_pkg.sv
package lbq_pkg;
  typedef enum logic [1:0] {
    OP_CAPTURE = 2'b00,
    OP_DISCARD = 2'b01,
    OP_INVAL   = 2'b10,
    OP_NONE    = 2'b11
  } lbq_op_e;
endpackage

// File: rtl/lbq_store.sv
// Compacted record storage: slot 0 is the oldest record, slots below
// count are live. Removal at any slot shifts every younger record down.
module lbq_store #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          clear,
  input  logic          pop,
  input  logic [CW-1:0] pop_idx,
  input  logic [CW-1:0] rd_idx,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count
);

  logic [AW-1:0] addr_q  [DEPTH];
  logic [DW-1:0] data_q  [DEPTH];
  logic [AW-1:0] addr_d  [DEPTH];
  logic [DW-1:0] data_d  [DEPTH];
  logic [AW-1:0] addr_up [DEPTH];
  logic [DW-1:0] data_up [DEPTH];

  // Source of each slot when records above it move down by one.
  for (genvar i = 0; i < DEPTH; i++) begin : g_shift_src
    if (i < DEPTH - 1) begin : g_mid
      assign addr_up[i] = addr_q[i+1];
      assign data_up[i] = data_q[i+1];
    end else begin : g_top
      assign addr_up[i] = addr_q[i];
      assign data_up[i] = data_q[i];
    end
  end

  logic room;
  assign room = (count != CW'(DEPTH));

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      addr_d[i] = addr_q[i];
      data_d[i] = data_q[i];
      if (pop && (CW'(i) >= pop_idx)) begin
        addr_d[i] = addr_up[i];
        data_d[i] = data_up[i];
      end else if (push && room && (count == CW'(i))) begin
        addr_d[i] = push_addr;
        data_d[i] = push_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end
      count <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        addr_q[i] <= addr_d[i];
        data_q[i] <= data_d[i];
      end
      if (clear) begin
        count <= '0;
      end else if (push && room) begin
        count <= count + CW'(1);
      end else if (pop && (count != '0)) begin
        count <= count - CW'(1);
      end
    end
  end

  assign rd_addr = addr_q[IW'(rd_idx)];
  assign rd_data = data_q[IW'(rd_idx)];

endmodule

// File: rtl/lbq_scan.sv
// Invalidate walker: visits one slot per cycle, offers a write for a
// slot in the target line and stays on that slot until the write is taken.
module lbq_scan #(
  parameter int DEPTH     = 8,
  parameter int AW        = 32,
  parameter int LINE_BITS = 5,
  localparam int CW       = $clog2(DEPTH + 1),
  localparam int TW       = AW - LINE_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] count,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_ready,
  output logic          busy,
  output logic [CW-1:0] idx,
  output logic          wr_valid,
  output logic          pop
);

  logic [TW-1:0] tag_q;
  logic          in_range;
  logic          hit;

  assign in_range = (idx < count);
  assign hit      = in_range && (rd_addr[AW-1:LINE_BITS] == tag_q);
  assign wr_valid = busy && hit;
  assign pop      = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      tag_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      idx   <= '0;
      tag_q <= start_addr[AW-1:LINE_BITS];
    end else if (busy) begin
      if (!in_range) begin
        busy <= 1'b0;
      end else if (!hit) begin
        idx <= idx + CW'(1);
      end
    end
  end

endmodule

// File: rtl/lbq_top.sv
module lbq_top
  import lbq_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int LINE_BITS = 5,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic          cmd_cacheable,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          busy,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          overflow
);

  lbq_op_e       op;
  logic          accept;
  logic          do_capture;
  logic          do_push;
  logic          do_clear;
  logic          do_start;
  logic          do_pop;
  logic [CW-1:0] scan_idx;
  logic          overflow_q;

  assign op         = lbq_op_e'(cmd_op);
  assign cmd_ready  = !busy;
  assign accept     = cmd_valid && cmd_ready;
  assign do_capture = accept && (op == OP_CAPTURE) && cmd_cacheable;
  assign do_push    = do_capture && !full;
  assign do_clear   = accept && (op == OP_DISCARD);
  assign do_start   = accept && (op == OP_INVAL);

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  lbq_store #(
    .DEPTH(DEPTH),
    .AW   (AW),
    .DW   (DW)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (do_push),
    .push_addr(cmd_addr),
    .push_data(cmd_data),
    .clear    (do_clear),
    .pop      (do_pop),
    .pop_idx  (scan_idx),
    .rd_idx   (scan_idx),
    .rd_addr  (wr_addr),
    .rd_data  (wr_data),
    .count    (count)
  );

  lbq_scan #(
    .DEPTH    (DEPTH),
    .AW       (AW),
    .LINE_BITS(LINE_BITS)
  ) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (do_start),
    .start_addr(cmd_addr),
    .count     (count),
    .rd_addr   (wr_addr),
    .wr_ready  (wr_ready),
    .busy      (busy),
    .idx       (scan_idx),
    .wr_valid  (wr_valid),
    .pop       (do_pop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overflow_q <= 1'b0;
    end else begin
      overflow_q <= do_capture && full;
    end
  end

  assign overflow = overflow_q;

endmodule

// File: rtl/lbq_checker.sv
module lbq_checker
  import lbq_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int LINE_BITS = 5,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_op,
  input logic [AW-1:0] cmd_addr,
  input logic [DW-1:0] cmd_data,
  input logic          cmd_cacheable,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          busy,
  input logic [CW-1:0] count,
  input logic          full,
  input logic          empty,
  input logic          overflow
);

  logic acc;
  assign acc = cmd_valid && cmd_ready;

  logic [AW-1:LINE_BITS] line_chk;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_chk <= '0;
    end else if (acc && (cmd_op == OP_INVAL)) begin
      line_chk <= cmd_addr[AW-1:LINE_BITS];
    end
  end

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r2_capture_appends: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (cmd_op == OP_CAPTURE) && cmd_cacheable && (count != CW'(DEPTH))
    |=> count == CW'($past(count) + CW'(1)));

  a_r2_uncached_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (cmd_op == OP_CAPTURE) && !cmd_cacheable |=> $stable(count));

  a_r3_overflow_drop: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (cmd_op == OP_CAPTURE) && cmd_cacheable && (count == CW'(DEPTH))
    |=> overflow && (count == CW'(DEPTH)));

  a_r3_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && (cmd_op == OP_CAPTURE) && cmd_cacheable && full) |=> !overflow);

  a_r4_discard_empties: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (cmd_op == OP_DISCARD) |=> (count == '0) && !wr_valid);

  a_r5_line_match: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_addr[AW-1:LINE_BITS] == line_chk);

  a_r5_write_removes: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> count == CW'($past(count) - CW'(1)));

  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  a_r8_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid);

  a_r8_inval_busy: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (cmd_op == OP_INVAL) |=> busy);

  a_r9_noop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (cmd_op == OP_NONE) |=> $stable(count) && !busy);

endmodule

bind lbq_top lbq_checker #(
  .DEPTH    (DEPTH),
  .AW       (AW),
  .DW       (DW),
  .LINE_BITS(LINE_BITS)
) u_lbq_checker (.*);

// File: tb/lbq_top_tb_top.sv
module lbq_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'b11;
  logic [31:0] cmd_addr = '0;
  logic [31:0] cmd_data = '0;
  logic        cmd_cacheable = 1'b0;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [31:0] wr_addr;
  logic [31:0] wr_data;
  logic        busy;
  logic [3:0]  count;
  logic        full;
  logic        empty;
  logic        overflow;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lbq_top dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_cacheable(cmd_cacheable), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .count(count),
    .full(full), .empty(empty), .overflow(overflow)
  );

  // {op, addr, data, cacheable}
  localparam logic [66:0] VEC [NV] = '{
    {2'b00, 32'h0000_1000, 32'h0000_0011, 1'b1},
    {2'b00, 32'h0000_1024, 32'h0000_0022, 1'b1},
    {2'b00, 32'h0000_101C, 32'h0000_0033, 1'b1},
    {2'b00, 32'h0000_2000, 32'h0000_0044, 1'b0},
    {2'b00, 32'h0000_1004, 32'h0000_0055, 1'b1},
    {2'b10, 32'h0000_1010, 32'h0000_0000, 1'b0},
    {2'b00, 32'h0000_3000, 32'h0000_0066, 1'b1},
    {2'b11, 32'h0000_1000, 32'h0000_0099, 1'b1},
    {2'b10, 32'h0000_103F, 32'h0000_0000, 1'b0},
    {2'b10, 32'h0000_5000, 32'h0000_0000, 1'b0},
    {2'b00, 32'h0000_301F, 32'h0000_0077, 1'b1},
    {2'b01, 32'h0000_0000, 32'h0000_0000, 1'b0},
    {2'b10, 32'h0000_3000, 32'h0000_0000, 1'b0},
    {2'b00, 32'h0000_4000, 32'h0000_0088, 1'b1},
    {2'b10, 32'h0000_4004, 32'h0000_0000, 1'b0}
  };

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_a [8];
  logic [31:0] m_d [8];
  int          m_n = 0;
  logic [31:0] e_a [8];
  logic [31:0] e_d [8];
  int          e_n = 0;

  task automatic check_eq(input string req, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Bench model of the queue, written from R2..R6.
  task automatic model_capture(input logic [31:0] a, input logic [31:0] d,
                               input logic c);
    if (c && m_n < 8) begin
      m_a[m_n] = a;
      m_d[m_n] = d;
      m_n++;
    end
  endtask

  task automatic model_inval(input logic [31:0] a);
    int keep;
    keep = 0;
    e_n = 0;
    for (int i = 0; i < m_n; i++) begin
      if (m_a[i][31:5] == a[31:5]) begin
        e_a[e_n] = m_a[i];
        e_d[e_n] = m_d[i];
        e_n++;
      end else begin
        m_a[keep] = m_a[i];
        m_d[keep] = m_d[i];
        keep++;
      end
    end
    m_n = keep;
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] d, input logic c);
    @(negedge clk);
    while (busy) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = op;
    cmd_addr = a;
    cmd_data = d;
    cmd_cacheable = c;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Called at the negedge after an invalidate was accepted.
  task automatic run_scan(input string req, input bit stall, input bit poke);
    int got;
    bit held;
    bit toggle;
    logic [31:0] ha;
    logic [31:0] hd;
    got = 0;
    held = 1'b0;
    toggle = 1'b0;
    check_eq("R8", "busy after invalidate", {63'd0, busy}, 64'd1);
    if (poke) begin
      cmd_valid = 1'b1;
      cmd_op = 2'b00;
      cmd_addr = 32'h0000_7000;
      cmd_data = 32'h0000_00EE;
      cmd_cacheable = 1'b1;
    end
    while (busy) begin
      check_eq("R8", "cmd_ready during scan", {63'd0, cmd_ready}, 64'd0);
      if (held) begin
        check_eq("R7", "valid held", {63'd0, wr_valid}, 64'd1);
        check_eq("R7", "addr held", {32'd0, wr_addr}, {32'd0, ha});
        check_eq("R7", "data held", {32'd0, wr_data}, {32'd0, hd});
      end
      held = 1'b0;
      if (wr_valid) begin
        toggle = !toggle;
        if (stall && toggle) begin
          wr_ready = 1'b0;
          held = 1'b1;
          ha = wr_addr;
          hd = wr_data;
        end else begin
          wr_ready = 1'b1;
          if (got < e_n) begin
            check_eq(req, "write address", {32'd0, wr_addr}, {32'd0, e_a[got]});
            check_eq(req, "write data", {32'd0, wr_data}, {32'd0, e_d[got]});
          end
          got++;
        end
      end else begin
        wr_ready = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    wr_ready = 1'b0;
    check_eq(req, "number of writes", 64'(got), 64'(e_n));
    check_eq("R8", "wr_valid after scan", {63'd0, wr_valid}, 64'd0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", "count", 64'(count), 64'd0);
    check_eq("R1", "empty", {63'd0, empty}, 64'd1);
    check_eq("R1", "full", {63'd0, full}, 64'd0);
    check_eq("R1", "busy", {63'd0, busy}, 64'd0);
    check_eq("R1", "wr_valid", {63'd0, wr_valid}, 64'd0);
    check_eq("R1", "overflow", {63'd0, overflow}, 64'd0);
    check_eq("R1", "cmd_ready", {63'd0, cmd_ready}, 64'd1);

    // Table walk
    for (int k = 0; k < NV; k++) begin
      logic [1:0]  op;
      logic [31:0] a;
      logic [31:0] d;
      logic        c;
      op = VEC[k][66:65];
      a  = VEC[k][64:33];
      d  = VEC[k][32:1];
      c  = VEC[k][0];
      if (op == 2'b10) model_inval(a);
      issue(op, a, d, c);
      case (op)
        2'b00: begin
          model_capture(a, d, c);
          check_eq("R2", "count after capture", 64'(count), 64'(m_n));
        end
        2'b01: begin
          m_n = 0;
          check_eq("R4", "count after discard", 64'(count), 64'd0);
          check_eq("R4", "no write after discard", {63'd0, wr_valid}, 64'd0);
        end
        2'b10: begin
          run_scan("R5", k[0], 1'b0);
          check_eq("R6", "count after invalidate", 64'(count), 64'(m_n));
        end
        default: begin
          check_eq("R9", "count after no-op", 64'(count), 64'(m_n));
          check_eq("R9", "busy after no-op", {63'd0, busy}, 64'd0);
        end
      endcase
    end

    // Overflow at depth, then a stalled full-line drain with a blocked capture
    issue(2'b01, 32'h0, 32'h0, 1'b0);
    m_n = 0;
    for (int i = 0; i < 8; i++) begin
      issue(2'b00, 32'h0000_6000 + 32'(4 * i), 32'h0000_00A0 + 32'(i), 1'b1);
      model_capture(32'h0000_6000 + 32'(4 * i), 32'h0000_00A0 + 32'(i), 1'b1);
    end
    check_eq("R3", "full at depth", {63'd0, full}, 64'd1);
    check_eq("R3", "count at depth", 64'(count), 64'd8);
    check_eq("R3", "no overflow before drop", {63'd0, overflow}, 64'd0);
    issue(2'b00, 32'h0000_6100, 32'h0000_00FF, 1'b1);
    check_eq("R3", "overflow pulse", {63'd0, overflow}, 64'd1);
    check_eq("R3", "count kept after drop", 64'(count), 64'd8);
    @(negedge clk);
    check_eq("R3", "overflow one cycle", {63'd0, overflow}, 64'd0);
    model_inval(32'h0000_6010);
    issue(2'b10, 32'h0000_6010, 32'h0, 1'b0);
    run_scan("R5", 1'b1, 1'b1);
    check_eq("R8", "capture blocked during scan", 64'(count), 64'd0);
    check_eq("R8", "empty after drain", {63'd0, empty}, 64'd1);

    // Reset from a non-empty state
    issue(2'b00, 32'h0000_8000, 32'h0000_0001, 1'b1);
    check_eq("R2", "count before reset", 64'(count), 64'd1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", "count after reset", 64'(count), 64'd0);
    check_eq("R1", "empty after reset", {63'd0, empty}, 64'd1);

    finish_run();
  end

endmodule